// File: doc/BRIEF.md
# Twin-Precision Signed Multiplier

This block multiplies two 16-bit integers, as two's complement or as unsigned values, and can share its one partial-product array between three kinds of work. The full mode forms one 32-bit product of the whole operands. The half mode forms one 16-bit product of the low operand bytes and keeps every other partial-product bit at zero. The twin mode forms two independent 16-bit products at once: one of the low bytes and one of the high bytes.

A single array of AND terms is gated by the mode. Terms outside the active sub-products are held at zero, and each sub-product receives its own signed sign-bit inversions and correction constants. A carry-save tree reduces the array to two rows, and a parallel-prefix adder adds them. In the split modes a carry is never allowed to pass the boundary between the two result halves. An optional output register, selected by a parameter, adds one clock of latency.

Top module: `tpmul_top`

## Requirements
- R1: With `mode` = 2'b00, `p` equals the 32-bit product of `a` and `b`. The operands are two's complement when `sgn` = 1 and unsigned when `sgn` = 0.
- R2: With `mode` = 2'b01, `p[15:0]` equals the 16-bit product of `a[7:0]` and `b[7:0]` (signed when `sgn` = 1), `p[31:16]` is zero, and `a[15:8]` and `b[15:8]` have no effect on `p`.
- R3: With `mode` = 2'b10, `p[15:0]` equals the 16-bit product of `a[7:0]` and `b[7:0]`, signed or unsigned according to `sgn`.
- R4: With `mode` = 2'b10, `p[31:16]` equals the 16-bit product of `a[15:8]` and `b[15:8]`, with no carry from the low product. This includes signed low operands of zero, where the signed correction terms alone would overflow bit 15.
- R5: With `mode` = 2'b11, the result is the same as in full mode (R1).
- R6: Extreme signed operands produce exact results: -32768 x -32768 = 32'h4000_0000 in full mode, and -128 x -128 = 16'h4000 in each half-width product.
- R7: With `OUT_REG` = 1 (default), `p` shows the result for the inputs present at a rising clock edge from that edge on, and it does not change before that edge.
- R8: While `rst_n` is low, the output register holds `p` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | 16 | Multiplicand |
| b | input | 16 | Multiplier |
| mode | input | 2 | 00 full, 01 single half, 10 twin, 11 full |
| sgn | input | 1 | 1 = two's complement operands, 0 = unsigned |
| p | output | 32 | Result word, laid out by mode |

## Verification
With the default output register, every result is due one rising edge after its operands, mode and sign control are applied. The bench changes inputs only on falling edges and compares `p` at the next falling edge, after exactly one rising edge. This places each comparison half a cycle after the register loads, and far from the next load. Once, just after new inputs are driven and before the edge, the bench confirms that `p` still holds the previous result. The twin-mode sweep covers every pair of low bytes with both sign settings, and each such vector carries a distinct pair of high bytes, so both halves and the boundary between them are compared on every vector.

// File: rtl/tpmul_pkg.sv
package tpmul_pkg;

  typedef enum logic [1:0] {
    MD_FULL = 2'b00,
    MD_HALF = 2'b01,
    MD_TWIN = 2'b10,
    MD_ALTF = 2'b11
  } tp_mode_e;

  // rows left after lvl levels of 3:2 compression
  function automatic int csa_rows_after(int n, int lvl);
    int k;
    int m;
    m = n;
    for (k = 0; k < lvl; k++) m = m - m / 3;
    return m;
  endfunction

  // levels needed to bring n rows down to two
  function automatic int csa_levels(int n);
    int l;
    int m;
    l = 0;
    m = n;
    while (m > 2) begin
      m = m - m / 3;
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/tpmul_ppgen.sv
// Mode-gated partial-product array with signed sign-bit handling.
// Row i holds the terms a[j] & b[i] at weight i+j; row W holds constants.
module tpmul_ppgen #(
  parameter int W  = 16,
  parameter int NR = W + 1
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  input  logic           full_on,
  input  logic           part_lo,
  input  logic           part_hi,
  output logic [2*W-1:0] rows [NR]
);
  localparam int H = W / 2;

  logic split;
  assign split = part_lo | part_hi;

  always_comb begin
    for (int r = 0; r < NR; r++) rows[r] = '0;
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        rows[i][i+j] =
          (full_on | (part_lo & (i < H) & (j < H)) | (part_hi & (i >= H) & (j >= H)))
          & ((a[j] & b[i]) ^ (sgn & (
              (split ? ((i == H-1) || (i == W-1)) : (i == W-1)) ^
              (split ? ((j == H-1) || (j == W-1)) : (j == W-1)))));
      end
    end
    // correction constants at the sign positions of each active product
    rows[W][H]     = sgn & part_lo;
    rows[W][W-1]   = sgn & part_lo;
    rows[W][W]     = sgn & full_on;
    rows[W][W+H]   = sgn & part_hi;
    rows[W][2*W-1] = sgn & (full_on | part_hi);
  end

endmodule

// File: rtl/tpmul_csatree.sv
// Carry-save reduction tree; rows enter in order so low-weight rows
// meet first. In split modes no carry lands on bit CUT.
module tpmul_csatree #(
  parameter int NR  = 17,
  parameter int PW  = 32,
  parameter int CUT = 16
) (
  input  logic [PW-1:0] rows [NR],
  input  logic          split,
  output logic [PW-1:0] sum_o,
  output logic [PW-1:0] car_o
);
  localparam int NL = tpmul_pkg::csa_levels(NR);
  localparam logic [PW-1:0] CUT_BIT = PW'(1) << CUT;

  logic [PW-1:0] lv [NL+1][NR];
  logic [PW-1:0] kill;

  assign kill = split ? CUT_BIT : '0;

  for (genvar r = 0; r < NR; r++) begin : g_in
    assign lv[0][r] = rows[r];
  end

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    localparam int NI = tpmul_pkg::csa_rows_after(NR, l);
    localparam int NG = NI / 3;
    for (genvar g = 0; g < NG; g++) begin : g_csa
      logic [PW-1:0] x, y, z;
      logic [PW-2:0] maj;
      assign x   = lv[l][3*g];
      assign y   = lv[l][3*g+1];
      assign z   = lv[l][3*g+2];
      assign maj = (x[PW-2:0] & y[PW-2:0]) | (x[PW-2:0] & z[PW-2:0]) |
                   (y[PW-2:0] & z[PW-2:0]);
      assign lv[l+1][2*g]   = x ^ y ^ z;
      assign lv[l+1][2*g+1] = {maj, 1'b0} & ~kill;
    end
    for (genvar r = 3*NG; r < NI; r++) begin : g_pass
      assign lv[l+1][r-NG] = lv[l][r];
    end
    for (genvar r = NI-NG; r < NR; r++) begin : g_zero
      assign lv[l+1][r] = '0;
    end
  end

  assign sum_o = lv[NL][0];
  assign car_o = lv[NL][1];

endmodule

// File: rtl/tpmul_ksadd.sv
// Kogge-Stone final adder; in split modes the carry into bit CUT is cut.
module tpmul_ksadd #(
  parameter int PW  = 32,
  parameter int CUT = 16
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  input  logic          split,
  output logic [PW-1:0] s
);
  localparam int NS = $clog2(PW);
  localparam logic [PW-1:0] EDGE_BIT = PW'(1) << (CUT - 1);

  logic [PW-1:0] hp;
  logic [PW-1:0] cut_m;
  logic [PW-1:0] gg [NS+1];
  logic [PW-1:0] pp [NS];

  assign hp    = x ^ y;
  assign cut_m = split ? EDGE_BIT : '0;
  assign gg[0] = (x & y) & ~cut_m;
  assign pp[0] = hp & ~cut_m;

  for (genvar st = 0; st < NS; st++) begin : g_st
    localparam int D = 1 << st;
    for (genvar i = 0; i < PW; i++) begin : g_bit
      if (i >= D) begin : g_mrg
        assign gg[st+1][i] = gg[st][i] | (pp[st][i] & gg[st][i-D]);
        if (st < NS - 1) begin : g_p
          assign pp[st+1][i] = pp[st][i] & pp[st][i-D];
        end
      end else begin : g_cpy
        assign gg[st+1][i] = gg[st][i];
        if (st < NS - 1) begin : g_p
          assign pp[st+1][i] = pp[st][i];
        end
      end
    end
  end

  assign s = hp ^ {gg[NS][PW-2:0], 1'b0};

endmodule

// File: rtl/tpmul_top.sv
module tpmul_top #(
  parameter int W       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [1:0]     mode,
  input  logic           sgn,
  output logic [2*W-1:0] p
);
  import tpmul_pkg::*;

  localparam int PW = 2 * W;
  localparam int NR = W + 1;

  tp_mode_e      md;
  logic          full_on, part_lo, part_hi, split;
  logic [PW-1:0] rows [NR];
  logic [PW-1:0] t_sum, t_car, prod;

  assign md      = tp_mode_e'(mode);
  assign full_on = (md == MD_FULL) || (md == MD_ALTF);
  assign part_lo = (md == MD_HALF) || (md == MD_TWIN);
  assign part_hi = (md == MD_TWIN);
  assign split   = part_lo;

  tpmul_ppgen #(.W(W), .NR(NR)) u_pp (
    .a       (a),
    .b       (b),
    .sgn     (sgn),
    .full_on (full_on),
    .part_lo (part_lo),
    .part_hi (part_hi),
    .rows    (rows)
  );

  tpmul_csatree #(.NR(NR), .PW(PW), .CUT(W)) u_tree (
    .rows  (rows),
    .split (split),
    .sum_o (t_sum),
    .car_o (t_car)
  );

  tpmul_ksadd #(.PW(PW), .CUT(W)) u_add (
    .x     (t_sum),
    .y     (t_car),
    .split (split),
    .s     (prod)
  );

  if (OUT_REG) begin : g_reg
    logic [PW-1:0] p_d, p_q;
    always_comb p_d = prod;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p_q <= '0;
      else        p_q <= p_d;
    end
    assign p = p_q;
  end else begin : g_comb
    assign p = prod;
  end

endmodule

// File: rtl/tpmul_chk.sv
module tpmul_chk #(
  parameter int W       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic [1:0]     mode,
  input logic           sgn,
  input logic [2*W-1:0] p
);
  localparam int H = W / 2;

  function automatic logic [2*W-1:0] mul_w(logic [W-1:0] x, logic [W-1:0] y, logic s);
    longint xv, yv;
    xv = s ? longint'($signed(x)) : longint'({1'b0, x});
    yv = s ? longint'($signed(y)) : longint'({1'b0, y});
    return (2*W)'(xv * yv);
  endfunction

  function automatic logic [W-1:0] mul_h(logic [H-1:0] x, logic [H-1:0] y, logic s);
    longint xv, yv;
    xv = s ? longint'($signed(x)) : longint'({1'b0, x});
    yv = s ? longint'($signed(y)) : longint'({1'b0, y});
    return W'(xv * yv);
  endfunction

  logic [W-1:0] a_d, b_d;
  logic [1:0]   m_d;
  logic         s_d, vld;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk) begin
      a_d <= a;
      b_d <= b;
      m_d <= mode;
      s_d <= sgn;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld <= 1'b0;
      else        vld <= 1'b1;
    end
  end else begin : g_now
    assign a_d = a;
    assign b_d = b;
    assign m_d = mode;
    assign s_d = sgn;
    assign vld = 1'b1;
  end

  // R1 R7
  full_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && m_d == 2'b00) |-> p == mul_w(a_d, b_d, s_d));
  // R5
  alt_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && m_d == 2'b11) |-> p == mul_w(a_d, b_d, s_d));
  // R2
  half_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && m_d == 2'b01) |-> p[W-1:0] == mul_h(a_d[H-1:0], b_d[H-1:0], s_d));
  // R2
  half_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && m_d == 2'b01) |-> p[2*W-1:W] == '0);
  // R3
  twin_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && m_d == 2'b10) |-> p[W-1:0] == mul_h(a_d[H-1:0], b_d[H-1:0], s_d));
  // R4
  twin_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && m_d == 2'b10) |-> p[2*W-1:W] == mul_h(a_d[W-1:H], b_d[W-1:H], s_d));

endmodule

bind tpmul_top tpmul_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/tb_tpmul_top.sv
module tb_tpmul_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;

  logic        clk;
  logic        rst_n;
  logic [15:0] a, b;
  logic [1:0]  mode;
  logic        sgn;
  logic [31:0] p;

  int n_chk;
  int n_fail;
  int cyc;

  tpmul_top dut (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .mode  (mode),
    .sgn   (sgn),
    .p     (p)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ef(logic [15:0] x, logic [15:0] y, logic s);
    longint xv, yv;
    xv = s ? longint'($signed(x)) : longint'({1'b0, x});
    yv = s ? longint'($signed(y)) : longint'({1'b0, y});
    return 32'(xv * yv);
  endfunction

  function automatic logic [15:0] eh(logic [7:0] x, logic [7:0] y, logic s);
    int xv, yv;
    xv = s ? int'($signed(x)) : int'({1'b0, x});
    yv = s ? int'($signed(y)) : int'({1'b0, y});
    return 16'(xv * yv);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h mode=%b sgn=%b actual=%h expected=%h",
               req, a, b, mode, sgn, act, exp);
    end
  endtask

  // drive at a falling edge, result due after the next rising edge
  task automatic run(logic [15:0] x, logic [15:0] y, logic [1:0] m, logic s);
    a = x; b = y; mode = m; sgn = s;
    @(posedge clk);
    @(negedge clk);
    case (m)
      2'b01: begin
        chk("R2", {16'h0, p[15:0]}, {16'h0, eh(x[7:0], y[7:0], s)});
        chk("R2", {16'h0, p[31:16]}, 32'h0);
      end
      2'b10: begin
        chk("R3", {16'h0, p[15:0]}, {16'h0, eh(x[7:0], y[7:0], s)});
        chk("R4", {16'h0, p[31:16]}, {16'h0, eh(x[15:8], y[15:8], s)});
      end
      2'b11:   chk("R5", p, ef(x, y, s));
      default: chk("R1", p, ef(x, y, s));
    endcase
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= WD_LIMIT) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cyc, WD_LIMIT);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    a = 16'h1234; b = 16'h4321; mode = 2'b00; sgn = 1'b1;
    repeat (3) @(negedge clk);
    // R8: inputs are active but reset holds the output at zero
    chk("R8", p, 32'h0);
    rst_n = 1'b1;
    a = 16'd3; b = 16'd5; mode = 2'b00; sgn = 1'b0;
    #1;
    // R7: no change before the rising edge
    chk("R7", p, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R7", p, 32'd15);

    // R6 corners
    run(16'h8000, 16'h8000, 2'b00, 1'b1);
    chk("R6", p, 32'h4000_0000);
    run(16'h8000, 16'h7FFF, 2'b00, 1'b1);
    run(16'hFFFF, 16'hFFFF, 2'b00, 1'b1);
    run(16'hFFFF, 16'hFFFF, 2'b00, 1'b0);
    chk("R1", p, 32'hFFFE_0001);
    run(16'h8000, 16'h8000, 2'b11, 1'b0);
    chk("R5", p, 32'h4000_0000);
    run(16'h3C80, 16'hC380, 2'b01, 1'b1);
    chk("R6", {16'h0, p[15:0]}, 32'h0000_4000);
    run(16'h8080, 16'h8080, 2'b10, 1'b1);
    chk("R6", p, 32'h4000_4000);
    // R4: signed low operands of zero next to a large high product
    run(16'h8000, 16'h8000, 2'b10, 1'b1);
    chk("R4", p, 32'h4000_0000);
    run(16'h7F80, 16'h8180, 2'b10, 1'b1);

    // full and alias-full, random vectors
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 2500; k++) begin
        run(16'($urandom), 16'($urandom), (k % 4 == 3) ? 2'b11 : 2'b00, s[0]);
      end
    end

    // single half: high bytes random and must not matter (R2)
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 4096; k++) begin
        run({8'($urandom), 8'(k * 37)}, {8'($urandom), 8'(k * 101 + k / 256)},
            2'b01, s[0]);
      end
    end

    // twin: every low-byte pair, with distinct high bytes
    for (int s = 0; s < 2; s++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          run({8'(x) ^ 8'hA5, 8'(x)}, {~8'(y), 8'(y)}, 2'b10, s[0]);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule